// File: doc/BRIEF.md
# ROM Read-Ahead Byte Buffer

This block sits between a fast processing core and a slow external ROM and hides most of the ROM's latency for single-byte data loads. The core writes a 16-bit pointer register. That write alone starts a background fetch from the 24-bit address built from an 8-bit bank register (upper byte) and the pointer (lower 16 bits). The core is not held up while the ROM works. Some cycles later it issues a read-byte request and collects the byte that was fetched.

The core is stalled only in two cases. The first is a read-byte request that comes before the fetch is finished. The second is an attempt to change the bank while a fetch is still outstanding. The external ROM port uses a request/acknowledge handshake, and the core may drive it only while the shared ROM bus is granted to it. A busy flag shows the core when a fetch is in progress.

Top module: `rom_prefetch_buf`

## Requirements
- R1: A pointer write starts a ROM access whose address is {bank register, written pointer}, with the bank in bits 23:16 and the pointer in bits 15:0.
- R2: While a fetch is outstanding, `core_stall` stays low as long as the core neither requests a byte nor writes the bank.
- R3: A read-byte request made while `busy` is high holds `core_stall` high until the fetch completes. This takes at most five core cycles with the default ROM latency and a granted bus. When the stall drops, `rd_data` is the byte returned by the ROM.
- R4: A bank write made while `busy` is high stalls the core until the fetch completes, and only then takes effect. The next fetch uses the new bank.
- R5: `busy` goes high in the cycle after a pointer write and stays high until the cycle after the ROM acknowledge of the last requested fetch. `rom_req` is never high while `busy` is low.
- R6: `rom_req` is high only while `rom_grant` is high. With the grant withheld, a requested fetch waits with `busy` high and goes out once the grant returns.
- R7: Once a fetch has completed, `rd_data` holds its byte until a later fetch completes. Repeated read-byte requests return that byte, cause no ROM access and are not stalled.
- R8: A pointer write during an access lets that access finish and then starts one more access with the newest pointer. Pointer writes made while the access is still waiting for the grant cause only one access, with the newest pointer. In both cases the core afterwards reads the byte at the newest address.
- R9: While `rom_req` is high and not yet acknowledged, `rom_addr` does not change.
- R10: After reset, `busy`, `core_stall` and `rom_req` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe; starts a fetch |
| ptr_wdata | input | 16 | New pointer value |
| bank_wr | input | 1 | Bank register write strobe; held by the core while stalled |
| bank_wdata | input | 8 | New bank value |
| rd_req | input | 1 | Read-byte request from the core |
| core_stall | output | 1 | Core must hold its current request |
| rd_data | output | 8 | Fetched byte |
| busy | output | 1 | Background ROM fetch in progress |
| rom_grant | input | 1 | ROM bus is granted to the core side |
| rom_req | output | 1 | ROM access request |
| rom_addr | output | 24 | ROM byte address |
| rom_ack | input | 1 | ROM data valid for the current request |
| rom_rdata | input | 8 | ROM read data |

## Verification
The assertions assume the following about the inputs:
- `rom_ack` comes only while `rom_req` is high.
- The core keeps `rd_req` or `bank_wr` asserted for as long as `core_stall` is high.
- The core never issues a read-byte request in the same cycle as a pointer write.

The bench's ROM model acknowledges after a fixed count of granted request cycles. The bench drivers hold each request until they see the stall released, and they return from a pointer write before they issue any read. Grant withdrawal is applied only before an access is issued.

// File: rtl/rom_prefetch_buf.sv
module rom_prefetch_buf #(
  parameter int PTR_W  = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = PTR_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              rd_req,
  output logic              core_stall,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  input  logic              rom_grant,
  output logic              rom_req,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic              rom_ack,
  input  logic [DATA_W-1:0] rom_rdata
);

  logic [PTR_W-1:0]  ptr_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              pend_q;
  logic              inflt_q;
  logic              issue;
  logic              done;

  // pend_q: a fetch is wanted that has not yet been sent to the ROM
  assign issue      = pend_q && !inflt_q && rom_grant;
  assign rom_req    = inflt_q && rom_grant;
  assign done       = rom_req && rom_ack;
  assign busy       = pend_q || inflt_q;
  assign core_stall = busy && (rd_req || bank_wr);
  assign rd_data    = data_q;
  assign rom_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      bank_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      inflt_q <= 1'b0;
    end else begin
      if (ptr_wr)
        ptr_q <= ptr_wdata;
      if (bank_wr && !busy)
        bank_q <= bank_wdata;
      if (ptr_wr)
        pend_q <= 1'b1;
      else if (issue)
        pend_q <= 1'b0;
      if (issue) begin
        addr_q  <= {bank_q, ptr_q};
        inflt_q <= 1'b1;
      end else if (done) begin
        inflt_q <= 1'b0;
      end
      if (done)
        data_q <= rom_rdata;
    end
  end

endmodule

// File: rtl/rom_prefetch_buf_chk.sv
module rom_prefetch_buf_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_wr,
  input logic              bank_wr,
  input logic              rd_req,
  input logic              core_stall,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              rom_grant,
  input logic              rom_req,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_ack
);

  AST_PTR_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> busy); // R1
  AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !core_stall); // R2
  AST_EARLY_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_req) |-> core_stall); // R3
  AST_BANK_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bank_wr) |-> core_stall); // R4
  AST_REQ_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> busy); // R5
  AST_REQ_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> rom_grant); // R6
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ptr_wr) |=> $stable(rd_data)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ack) |=> $stable(rom_addr)); // R9

endmodule

bind rom_prefetch_buf rom_prefetch_buf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .bank_wr(bank_wr), .rd_req(rd_req),
  .core_stall(core_stall), .rd_data(rd_data), .busy(busy), .rom_grant(rom_grant),
  .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack)
);

// File: tb/test_rom_prefetch_buf.sv
module test_rom_prefetch_buf;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr = 1'b0;
  logic [15:0] ptr_wdata = '0;
  logic        bank_wr = 1'b0;
  logic [7:0]  bank_wdata = '0;
  logic        rd_req = 1'b0;
  logic        core_stall;
  logic [7:0]  rd_data;
  logic        busy;
  logic        rom_grant = 1'b1;
  logic        rom_req;
  logic [23:0] rom_addr;
  logic        rom_ack;
  logic [7:0]  rom_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int rcnt = 0;
  int n_acc = 0;
  logic [23:0] last_addr = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  rom_prefetch_buf i_rom_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata), .rd_req(rd_req),
    .core_stall(core_stall), .rd_data(rd_data), .busy(busy),
    .rom_grant(rom_grant), .rom_req(rom_req), .rom_addr(rom_addr),
    .rom_ack(rom_ack), .rom_rdata(rom_rdata)
  );

  function automatic logic [7:0] romf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  assign rom_ack   = rom_req && (rcnt == LAT - 1);
  assign rom_rdata = romf(rom_addr);

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt  <= 0;
      n_acc <= 0;
    end else if (rom_req) begin
      if (rom_ack) begin
        rcnt      <= 0;
        n_acc     <= n_acc + 1;
        last_addr <= rom_addr;
      end else begin
        rcnt <= rcnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_req && !core_stall) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R7 actual=%0h expected=none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ptr(input logic [15:0] v);
    ptr_wr = 1'b1;
    ptr_wdata = v;
    tick();
    ptr_wr = 1'b0;
  endtask

  task automatic wr_bank(input logic [7:0] v, output int st);
    logic s;
    bank_wr = 1'b1;
    bank_wdata = v;
    st = 0;
    do begin
      @(negedge clk);
      s = core_stall;
      if (s) st++;
    end while (s);
    tick();
    bank_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag, output int st);
    logic s;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_req = 1'b1;
    st = 0;
    do begin
      @(negedge clk);
      s = core_stall;
      if (s) st++;
    end while (s);
    tick();
    rd_req = 1'b0;
  endtask

  task automatic wait_idle;
    do @(negedge clk); while (busy);
    tick();
  endtask

  task automatic wait_req;
    do @(negedge clk); while (!rom_req);
    tick();
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int st, n0, cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 stall", core_stall, 0);
    check("R10 req", rom_req, 0);
    check("R10 data", rd_data, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1/R3/R5: bank 0x12, pointer 0x3456, early read
    wr_bank(8'h12, st);
    check("R4 idle bank write stall", st, 0);
    wr_ptr(16'h3456);
    check("R5 busy after write", busy, 1);
    wait_req();
    check("R1 rom_addr", rom_addr, 24'h123456);
    rd(romf(24'h123456), "R3 early read data", st);
    check("R3 stalled", st >= 1, 1);
    check("R3 stall bound", st <= 5, 1);
    check("R5 busy cleared", busy, 0);

    // R7: repeated reads, no new access
    n0 = n_acc;
    rd(romf(24'h123456), "R7 reread 1", st);
    check("R7 no stall", st, 0);
    rd(romf(24'h123456), "R7 reread 2", st);
    check("R7 no access", n_acc, n0);

    // R2: core runs freely while fetch outstanding
    wr_ptr(16'h0042);
    cnt = 0;
    repeat (3) begin
      @(negedge clk);
      if (core_stall) cnt++;
    end
    check("R2 no stall while busy", cnt, 0);
    wait_idle();
    rd(romf(24'h120042), "R2 data", st);

    // R4: bank write during fetch
    wr_ptr(16'h1000);
    wr_bank(8'h77, st);
    check("R4 bank write stalled", st >= 1, 1);
    check("R4 fetch done at release", last_addr, 24'h121000);
    wr_ptr(16'h0001);
    wait_idle();
    check("R4 new bank used", last_addr, 24'h770001);
    rd(romf(24'h770001), "R4 data", st);

    // R6: grant withheld
    rom_grant = 1'b0;
    wr_ptr(16'h2222);
    cnt = 0;
    repeat (8) begin
      @(negedge clk);
      if (rom_req) cnt++;
    end
    check("R6 no req without grant", cnt, 0);
    check("R6 busy while waiting", busy, 1);
    tick();
    rom_grant = 1'b1;
    wait_idle();
    check("R6 addr after grant", last_addr, 24'h772222);
    rd(romf(24'h772222), "R6 data", st);

    // R8: pointer write during in-flight access
    n0 = n_acc;
    wr_ptr(16'hAAAA);
    wait_req();
    wr_ptr(16'hBBBB);
    wait_idle();
    check("R8 two accesses", n_acc, n0 + 2);
    check("R8 newest addr", last_addr, 24'h77BBBB);
    rd(romf(24'h77BBBB), "R8 newest data", st);

    // R8: pointer writes while waiting for grant
    n0 = n_acc;
    rom_grant = 1'b0;
    wr_ptr(16'h0100);
    wr_ptr(16'h0200);
    tick();
    rom_grant = 1'b1;
    wait_idle();
    check("R8 single access", n_acc, n0 + 1);
    check("R8 waiting addr", last_addr, 24'h770200);
    rd(romf(24'h770200), "R8 waiting data", st);

    repeat (2) tick();
    summary();
  end
endmodule